// File: doc/BRIEF.md
# Timed Unlock Guard for Critical Control Bits

This block keeps a small set of critical control bits locked against stray writes. Software unlocks them by writing two key bytes, AAh and then 55h, to one unlock register address. Time is measured in instruction cycles. The processor gives a one-clock strobe at the end of each instruction cycle, and a write completes on the clock where that strobe is high. Two timers start together on the AAh write. A short one gives two instruction cycles for the 55h write. A long one, also counted from the AAh write, gives four instruction cycles in which one protected write may take place.

Because the long timer starts on the first key, the time left for the protected write depends on how long the 55h instruction took. A one-cycle instruction leaves three cycles. A two-cycle instruction leaves two. While the long window is still open, a new AAh write is ignored, so a second unlock sequence started too early fails. The block gives the register file a same-cycle qualifier for the protected write and a flag showing that it is unlocked.

The FSM has four states. `ST_LOCKED` is idle and locked. `ST_ARMED` waits for the second key. `ST_OPEN` is unlocked. `ST_SPENT` means the one write has been used and the long window is running out.

The transitions, all taken only on a strobe, are:
- LOCKED→ARMED on an AAh write to the unlock address.
- ARMED→OPEN on a 55h write by the second strobe after AAh.
- ARMED→LOCKED on any other write to the unlock address (abort), or when the second strobe passes without a key (key timeout).
- OPEN→SPENT when a protected write is accepted before the fourth strobe.
- OPEN→LOCKED on the fourth strobe after AAh (window expiry). This happens whether or not a write is accepted on that strobe.
- SPENT→LOCKED on the fourth strobe after AAh.

Top module: `ta_guard`

## Requirements
- R1: The unlock register is at address C7h. A write counts only when `bus_wr` and `cyc_stb` are both high. After an AAh write followed by a 55h write, `unlocked` goes high on the clock after the 55h write.
- R2: The 55h write must land on the first or second strobe after the AAh strobe. A 55h write on the third strobe leaves `unlocked` low.
- R3: While the block waits for 55h, a write of any other value to C7h aborts the sequence. A later 55h write then leaves `unlocked` low.
- R4: Protected writes are accepted up to and including the fourth strobe after the AAh strobe. If 55h lands on strobe 1, writes are accepted on strobes 2–4. If 55h lands on strobe 2, writes are accepted on strobes 3–4. `unlocked` drops on the clock after strobe 4.
- R5: While unlocked, `guard_wr_ok` is high in the same cycle as `guard_wr_req && cyc_stb`. Only one protected write is accepted per unlock: `unlocked` drops on the clock after the accepted write.
- R6: An AAh write before the fourth strobe after the previous AAh strobe does not start a sequence. The 55h and protected write that follow it are refused. An AAh write on the fifth strobe or later starts a sequence normally.
- R7: The timers advance only on `cyc_stb`. Clocks without a strobe leave `unlocked` and the window unchanged.
- R8: A protected write request made while locked keeps `guard_wr_ok` low.
- R9: Synchronous `rst` returns the block to locked with both timers cleared. A 55h write straight after reset does not unlock.
- R10: AAh and 55h written to any address other than C7h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-clock strobe at the end of each instruction cycle |
| bus_wr | input | 1 | Processor register write, valid with `cyc_stb` |
| bus_addr | input | 8 | Register address of the write |
| bus_wdata | input | 8 | Write data byte |
| guard_wr_req | input | 1 | Processor is trying to write the protected bits |
| guard_wr_ok | output | 1 | Protected write may take effect this cycle |
| unlocked | output | 1 | The protected window is open and not yet used |

## Verification
The assertions assume that every processor write and every protected-write request arrives on a clock where `cyc_stb` is high. They also assume the strobe is a single-clock pulse per instruction cycle. The stimulus meets both: every instruction cycle is one clock with no strobe followed by one strobe clock, and all writes and requests are driven only on the strobe clock. Multi-cycle instructions are modelled as extra strobes with no write, which keeps the cycle counts the same as in the requirements.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2,
        ST_SPENT  = 2'd3
    } ta_state_e;

    function automatic int unsigned ctr_width(input int unsigned span);
        return $clog2(span + 1);
    endfunction

endpackage

// File: rtl/ta_key_decode.sv
module ta_key_decode #(
    parameter int unsigned          ADDR_W      = 8,
    parameter int unsigned          DATA_W      = 8,
    parameter logic [ADDR_W-1:0]    UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0]    KEY_FIRST   = 8'hAA,
    parameter logic [DATA_W-1:0]    KEY_SECOND  = 8'h55
) (
    input  logic              cyc_stb,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              hit,
    output logic              is_first,
    output logic              is_second
);

    always_comb begin
        hit       = cyc_stb && bus_wr && (bus_addr == UNLOCK_ADDR);
        is_first  = (bus_wdata == KEY_FIRST);
        is_second = (bus_wdata == KEY_SECOND);
    end

endmodule

// File: rtl/ta_step_ctr.sv
module ta_step_ctr #(
    parameter int unsigned SPAN  = 4,
    parameter int unsigned CTR_W = ta_guard_pkg::ctr_width(SPAN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [CTR_W-1:0] elapsed_nxt
);

    localparam logic [CTR_W-1:0] CAP = CTR_W'(SPAN);

    logic [CTR_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (adv && count_q != CAP) begin
            count_q <= count_q + 1'b1;
        end
    end

    // strobes elapsed since the first key once the current strobe is counted
    always_comb begin
        elapsed_nxt = (count_q == CAP) ? CAP : count_q + 1'b1;
    end

endmodule

// File: rtl/ta_fsm.sv
module ta_fsm
    import ta_guard_pkg::*;
#(
    parameter int unsigned KEY_WIN  = 2,
    parameter int unsigned OPEN_WIN = 4,
    parameter int unsigned CTR_W    = ctr_width(OPEN_WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_stb,
    input  logic             hit,
    input  logic             is_first,
    input  logic             is_second,
    input  logic             guard_wr_req,
    input  logic [CTR_W-1:0] elapsed_nxt,
    output logic             ctr_clr,
    output logic             ctr_adv,
    output logic             guard_wr_ok,
    output logic             unlocked
);

    localparam logic [CTR_W-1:0] KEY_LIM  = CTR_W'(KEY_WIN);
    localparam logic [CTR_W-1:0] OPEN_LIM = CTR_W'(OPEN_WIN);

    ta_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (cyc_stb) begin
            unique case (state_q)
                ST_LOCKED: begin
                    if (hit && is_first) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (hit && is_second && elapsed_nxt <= KEY_LIM) state_d = ST_OPEN;
                    else if (hit)                                   state_d = ST_LOCKED;
                    else if (elapsed_nxt >= KEY_LIM)                state_d = ST_LOCKED;
                end
                ST_OPEN: begin
                    if (elapsed_nxt >= OPEN_LIM) state_d = ST_LOCKED;
                    else if (guard_wr_req)       state_d = ST_SPENT;
                end
                ST_SPENT: begin
                    if (elapsed_nxt >= OPEN_LIM) state_d = ST_LOCKED;
                end
                default: state_d = ST_LOCKED;
            endcase
        end
    end

    always_comb begin
        ctr_clr     = cyc_stb && hit && is_first && (state_q == ST_LOCKED);
        ctr_adv     = cyc_stb && (state_q != ST_LOCKED);
        unlocked    = (state_q == ST_OPEN);
        guard_wr_ok = unlocked && cyc_stb && guard_wr_req;
    end

endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST   = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND  = 8'h55,
    parameter int unsigned       KEY_WIN     = 2,
    parameter int unsigned       OPEN_WIN    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_stb,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              guard_wr_req,
    output logic              guard_wr_ok,
    output logic              unlocked
);

    localparam int unsigned CTR_W = ta_guard_pkg::ctr_width(OPEN_WIN);

    logic             hit, is_first, is_second;
    logic             ctr_clr, ctr_adv;
    logic [CTR_W-1:0] elapsed_nxt;

    ta_key_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_ADDR(UNLOCK_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) dec_i (
        .cyc_stb(cyc_stb), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hit(hit), .is_first(is_first),
        .is_second(is_second)
    );

    ta_step_ctr #(.SPAN(OPEN_WIN), .CTR_W(CTR_W)) ctr_i (
        .clk(clk), .rst(rst), .clr(ctr_clr), .adv(ctr_adv),
        .elapsed_nxt(elapsed_nxt)
    );

    ta_fsm #(.KEY_WIN(KEY_WIN), .OPEN_WIN(OPEN_WIN), .CTR_W(CTR_W)) fsm_i (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .hit(hit),
        .is_first(is_first), .is_second(is_second),
        .guard_wr_req(guard_wr_req), .elapsed_nxt(elapsed_nxt),
        .ctr_clr(ctr_clr), .ctr_adv(ctr_adv),
        .guard_wr_ok(guard_wr_ok), .unlocked(unlocked)
    );

endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_SECOND  = 8'h55,
    parameter int unsigned       OPEN_WIN    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_stb,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              guard_wr_req,
    input logic              guard_wr_ok,
    input logic              unlocked
);

    logic [7:0] open_stb_q;

    always_ff @(posedge clk) begin
        if (rst || !unlocked) begin
            open_stb_q <= '0;
        end else if (cyc_stb) begin
            open_stb_q <= open_stb_q + 1'b1;
        end
    end

    assert_unlock_after_key2_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(cyc_stb && bus_wr && bus_addr == UNLOCK_ADDR
                                  && bus_wdata == KEY_SECOND));

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
        unlocked |-> (open_stb_q <= 8'(OPEN_WIN - 2)));

    assert_single_write_R5: assert property (@(posedge clk) disable iff (rst)
        guard_wr_ok |=> !unlocked);

    assert_ok_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
        guard_wr_ok |-> (guard_wr_req && cyc_stb));

    assert_hold_no_stb_R7: assert property (@(posedge clk) disable iff (rst)
        !cyc_stb |=> $stable(unlocked));

    assert_locked_refuses_R8: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !guard_wr_ok);

    assert_reset_locks_R9: assert property (@(posedge clk)
        rst |=> !unlocked);

endmodule

bind ta_guard ta_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_ADDR(UNLOCK_ADDR),
    .KEY_SECOND(KEY_SECOND), .OPEN_WIN(OPEN_WIN)
) chk_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .guard_wr_req(guard_wr_req),
    .guard_wr_ok(guard_wr_ok), .unlocked(unlocked)
);

// File: tb/ta_guard_tb_top.sv
module ta_guard_tb_top;

    localparam logic [7:0] UA = 8'hC7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_stb = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       guard_wr_req = 1'b0;
    logic       guard_wr_ok;
    logic       unlocked;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    ta_guard dut_i (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .guard_wr_req(guard_wr_req), .guard_wr_ok(guard_wr_ok),
        .unlocked(unlocked)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected <= 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one instruction cycle: a clock without strobe, then the strobe clock
    task automatic instr(input logic wr, input logic [7:0] addr, input logic [7:0] data,
                         input logic req, output logic ok, output logic unl);
        @(negedge clk);
        cyc_stb = 0; bus_wr = 0; guard_wr_req = 0;
        @(negedge clk);
        cyc_stb = 1; bus_wr = wr; bus_addr = addr; bus_wdata = data; guard_wr_req = req;
        #2 ok = guard_wr_ok;
        @(posedge clk);
        #2 unl = unlocked;
        @(negedge clk);
        cyc_stb = 0; bus_wr = 0; guard_wr_req = 0;
    endtask

    task automatic nop(output logic ok, output logic unl);
        instr(1'b0, 8'h00, 8'h00, 1'b0, ok, unl);
    endtask

    task automatic flush();
        logic ok, unl;
        for (int i = 0; i < 5; i++) nop(ok, unl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        logic ok, unl;
        do_reset();
        #2 check("R9 reset locked", unlocked, 1'b0);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R9 55h after reset", unl, 1'b0);
        instr(0, 0, 0, 1, ok, unl);
        check("R8 req while locked", ok, 1'b0);
        // mid-window reset
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R1 unlock before reset", unl, 1'b1);
        do_reset();
        #2 check("R9 reset clears unlock", unlocked, 1'b0);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R9 timers cleared", unl, 1'b0);
        flush();
    endtask

    task automatic t_fast_key();
        logic ok, unl;
        instr(1, UA, 8'hAA, 0, ok, unl);
        check("R1 not unlocked after AAh only", unl, 1'b0);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R1 unlocked after 55h", unl, 1'b1);
        instr(0, 0, 0, 1, ok, unl);
        check("R5 write ok strobe2", ok, 1'b1);
        check("R5 lock after one write", unl, 1'b0);
        instr(0, 0, 0, 1, ok, unl);
        check("R5 second write refused", ok, 1'b0);
        flush();
        // 55h on strobe 1, write on strobe 4 (last one)
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        nop(ok, unl);
        nop(ok, unl);
        check("R4 still open after strobe3", unl, 1'b1);
        instr(0, 0, 0, 1, ok, unl);
        check("R4 write ok strobe4", ok, 1'b1);
        check("R4 closed after strobe4", unl, 1'b0);
        flush();
        // no write, expiry
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        nop(ok, unl); nop(ok, unl); nop(ok, unl);
        check("R4 expiry after strobe4", unl, 1'b0);
        instr(0, 0, 0, 1, ok, unl);
        check("R4 write strobe5 refused", ok, 1'b0);
        flush();
    endtask

    task automatic t_slow_key();
        logic ok, unl;
        instr(1, UA, 8'hAA, 0, ok, unl);
        nop(ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R2 55h at strobe2 unlocks", unl, 1'b1);
        nop(ok, unl);
        check("R4 open strobe3", unl, 1'b1);
        instr(0, 0, 0, 1, ok, unl);
        check("R4 write ok strobe4 slow", ok, 1'b1);
        flush();
        instr(1, UA, 8'hAA, 0, ok, unl);
        nop(ok, unl);
        nop(ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R2 55h at strobe3 fails", unl, 1'b0);
        flush();
    endtask

    task automatic t_abort();
        logic ok, unl;
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h12, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R3 abort then 55h", unl, 1'b0);
        instr(0, 0, 0, 1, ok, unl);
        check("R3 write after abort", ok, 1'b0);
        flush();
    endtask

    task automatic t_back_to_back();
        logic ok, unl;
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        instr(0, 0, 0, 1, ok, unl);
        check("R5 first access write", ok, 1'b1);
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R6 early second sequence stays locked", unl, 1'b0);
        instr(0, 0, 0, 1, ok, unl);
        check("R6 early second write refused", ok, 1'b0);
        flush();
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        instr(0, 0, 0, 1, ok, unl);
        nop(ok, unl);
        nop(ok, unl);
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R6 AAh at strobe5 works", unl, 1'b1);
        flush();
    endtask

    task automatic t_hold();
        logic ok, unl;
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        repeat (12) @(negedge clk);
        check("R7 hold without strobe", unlocked, 1'b1);
        nop(ok, unl); nop(ok, unl);
        check("R7 still open at strobe3", unl, 1'b1);
        nop(ok, unl);
        check("R7 closes at strobe4", unl, 1'b0);
        flush();
    endtask

    task automatic t_other_addr();
        logic ok, unl;
        instr(1, 8'hC6, 8'hAA, 0, ok, unl);
        instr(1, 8'hC6, 8'h55, 0, ok, unl);
        check("R10 wrong address ignored", unl, 1'b0);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R10 no sequence started", unl, 1'b0);
        instr(1, UA, 8'hAA, 0, ok, unl);
        instr(1, 8'h47, 8'h55, 0, ok, unl);
        instr(1, UA, 8'h55, 0, ok, unl);
        check("R10 wrong addr 55h no abort", unl, 1'b1);
        flush();
    endtask

    initial begin
        t_reset();
        t_fast_key();
        t_slow_key();
        t_abort();
        t_back_to_back();
        t_hold();
        t_other_addr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule